// File: doc/BRIEF.md
# Interleaved Vector Structure Load/Store Sequencer

This block takes a single structure load or store command and breaks it into a run of element-sized memory accesses that move data between memory and one to four consecutive 64-bit vector registers. A 4-bit layout code chooses how many registers take part, how far apart their elements sit in memory (the interleave factor) and the step between register indices. A 2-bit size code chooses the element width of 1, 2, 4 or 8 bytes.

For a load, the elements that return for one register are packed little-endian into a 64-bit word, and that word is written to the register file once, after its last element arrives. For a store, the register is read once before its first access and its elements are sent lowest first. Only one memory request is in flight at a time. A pulse on `done` marks the end of a command, and a pulse on `err` marks a rejected layout code.

Top module: `vstruct_seq`

## Requirements
- R1: Layout codes 0 to 10 select (registers, interleave, spacing) as follows: 0=(4,4,1), 1=(4,4,2), 2=(4,1,1), 3=(4,2,1), 4=(3,3,1), 5=(3,3,2), 6=(3,1,1), 7=(1,1,1), 8=(2,2,1), 9=(2,2,2), 10=(2,1,1). Exactly that many registers are transferred.
- R2: For size code s, each element is 2^s bytes, `mem_req_size` equals s, and each register takes 8>>s accesses.
- R3: Inside one register, consecutive element addresses differ by 2^s times the interleave factor.
- R4: Register k starts at base + k·2^s when interleave is above 2, or when interleave is 2 with two registers. With interleave 2 and four registers, register 2 starts at base + 2^s. In every other case a register starts one stride past the previous register's last element. Register 0 starts at base.
- R5: On a load, element i of a register fills bits [i·8·2^s +: 8·2^s] from the low 8·2^s bits of `mem_rsp_rdata`, and higher response bits are discarded. Each register is written exactly once, after its last response. Register indices are first, first+spacing, and so on, modulo 32. No register read takes place.
- R6: On a store, each register is read once, before its first access, at the same index sequence as R5. Element i is sent in the low bits of `mem_req_wdata` with all higher bits zero, in order of rising i. No register write takes place.
- R7: Only one request is outstanding at a time. No new request is made while a load response is due. A request that is not accepted holds its address and data until it is accepted.
- R8: A command with layout code 11 to 15 causes a one-cycle `err` pulse in the cycle after it is accepted. It causes no memory access, no register access and no `done`.
- R9: After reset, and between commands, `cmd_ready` is high and no request or register access is active. The first request appears in the second cycle after the command is accepted. `done` is a single-cycle pulse at the end of each accepted valid command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle and taking a command |
| cmd_layout | input | 4 | Layout code |
| cmd_esize | input | 2 | Element size code |
| cmd_load | input | 1 | 1 = load, 0 = store |
| cmd_reg | input | 5 | First register index |
| cmd_base | input | 32 | Base byte address |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 32 | Element byte address |
| mem_req_size | output | 2 | Element size code |
| mem_req_write | output | 1 | 1 = write access |
| mem_req_wdata | output | 64 | Store element, low-aligned |
| mem_rsp_valid | input | 1 | Load data returned |
| mem_rsp_rdata | input | 64 | Load data, element in low bits |
| rf_rd_en | output | 1 | Register read strobe |
| rf_rd_idx | output | 5 | Register read index |
| rf_rd_data | input | 64 | Register read data, same cycle |
| rf_wr_en | output | 1 | Register write strobe |
| rf_wr_idx | output | 5 | Register write index |
| rf_wr_data | output | 64 | Assembled register value |
| done | output | 1 | Command finished |
| err | output | 1 | Layout code rejected |

## Verification
A command accepted at an edge is followed by one set-up cycle with no request, and the request shows up in the cycle after that. The bench samples on falling edges, so it tests both of those cycles directly. A rejected code raises `err` in the first cycle after acceptance, and that pulse is gone by the next falling edge. A load's register write comes one cycle after its last response, and `done` comes one cycle after the final register step. Because memory stalls make the total length vary, the bench logs every access, register read and register write as they happen, counts `done` pulses until completion, and then compares the whole logs against sequences it builds itself from the layout table and the start-address rules.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  localparam int VS_DW      = 64;
  localparam int VS_LAYOUTS = 11;

  typedef struct packed {
    logic [2:0] nregs;
    logic [2:0] ilv;
    logic [1:0] spc;
  } vs_layout_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_REQ, S_WAIT, S_NEXT, S_FIN
  } vs_state_t;

  function automatic vs_layout_t vs_decode(input logic [3:0] code);
    vs_layout_t l;
    case (code)
      4'd0:    l = '{3'd4, 3'd4, 2'd1};
      4'd1:    l = '{3'd4, 3'd4, 2'd2};
      4'd2:    l = '{3'd4, 3'd1, 2'd1};
      4'd3:    l = '{3'd4, 3'd2, 2'd1};
      4'd4:    l = '{3'd3, 3'd3, 2'd1};
      4'd5:    l = '{3'd3, 3'd3, 2'd2};
      4'd6:    l = '{3'd3, 3'd1, 2'd1};
      4'd8:    l = '{3'd2, 3'd2, 2'd1};
      4'd9:    l = '{3'd2, 3'd2, 2'd2};
      4'd10:   l = '{3'd2, 3'd1, 2'd1};
      default: l = '{3'd1, 3'd1, 2'd1};
    endcase
    return l;
  endfunction

  // elements per 64-bit register
  function automatic logic [3:0] vs_elems(input logic [1:0] sz);
    return 4'd8 >> sz;
  endfunction

  function automatic logic [VS_DW-1:0] vs_mask(input logic [1:0] sz);
    logic [VS_DW:0] one;
    logic [VS_DW:0] m;
    one = 1;
    m   = (one << (7'd8 << sz)) - 1'b1;
    return m[VS_DW-1:0];
  endfunction

  function automatic logic [5:0] vs_shamt(input logic [1:0] sz, input logic [2:0] idx);
    logic [6:0] t;
    t = {1'b0, idx, 3'b000} << sz;
    return t[5:0];
  endfunction

  function automatic logic [VS_DW-1:0] vs_place(input logic [VS_DW-1:0] acc,
      input logic [VS_DW-1:0] data, input logic [1:0] sz, input logic [2:0] idx);
    return acc | ((data & vs_mask(sz)) << vs_shamt(sz, idx));
  endfunction

  function automatic logic [VS_DW-1:0] vs_pick(input logic [VS_DW-1:0] data,
      input logic [1:0] sz, input logic [2:0] idx);
    return (data >> vs_shamt(sz, idx)) & vs_mask(sz);
  endfunction
endpackage

// File: rtl/vseq_decode.sv
module vseq_decode
  import vseq_pkg::*;
(
  input  logic [3:0]  code,
  output vs_layout_t  lay,
  output logic        ok
);
  always_comb begin
    lay = vs_decode(code);
    ok  = (32'(code) < VS_LAYOUTS);
  end
endmodule

// File: rtl/vseq_agen.sv
module vseq_agen #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_cmd,
  input  logic [ADDR_W-1:0] base,
  input  logic              reg_begin,
  input  logic              step,
  input  logic [2:0]        nregs,
  input  logic [2:0]        ilv,
  input  logic [1:0]        sz,
  input  logic [2:0]        kreg,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] base_q, addr_q, esz, stride, start_addr;
  logic              own_lane, pair_restart;

  always_comb begin
    esz          = ADDR_W'(1) << sz;
    stride       = ADDR_W'(ilv) << sz;
    own_lane     = (ilv > 3'd2) || (ilv == 3'd2 && nregs == 3'd2);
    pair_restart = (ilv == 3'd2) && (nregs == 3'd4) && (kreg == 3'd2);
    if (own_lane)          start_addr = base_q + (ADDR_W'(kreg) << sz);
    else if (pair_restart) start_addr = base_q + esz;
    else                   start_addr = addr_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      addr_q <= '0;
    end else if (load_cmd) begin
      base_q <= base;
      addr_q <= base;
    end else if (reg_begin) begin
      addr_q <= start_addr;
    end else if (step) begin
      addr_q <= addr_q + stride;
    end
  end

  assign addr = addr_q;
endmodule

// File: rtl/vseq_dpath.sv
module vseq_dpath
  import vseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             clear,
  input  logic             rsp_take,
  input  logic [1:0]       sz,
  input  logic [2:0]       elem,
  input  logic [VS_DW-1:0] rf_data,
  input  logic [VS_DW-1:0] rsp_data,
  output logic [VS_DW-1:0] wdata,
  output logic [VS_DW-1:0] word
);
  logic [VS_DW-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        word_q <= '0;
    else if (capture)  word_q <= rf_data;
    else if (clear)    word_q <= '0;
    else if (rsp_take) word_q <= vs_place(word_q, rsp_data, sz, elem);
  end

  assign wdata = vs_pick(word_q, sz, elem);
  assign word  = word_q;
endmodule

// File: rtl/vstruct_seq.sv
module vstruct_seq
  import vseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [3:0]        cmd_layout,
  input  logic [1:0]        cmd_esize,
  input  logic              cmd_load,
  input  logic [IDX_W-1:0]  cmd_reg,
  input  logic [ADDR_W-1:0] cmd_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [1:0]        mem_req_size,
  output logic              mem_req_write,
  output logic [63:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_rdata,
  output logic              rf_rd_en,
  output logic [IDX_W-1:0]  rf_rd_idx,
  input  logic [63:0]       rf_rd_data,
  output logic              rf_wr_en,
  output logic [IDX_W-1:0]  rf_wr_idx,
  output logic [63:0]       rf_wr_data,
  output logic              done,
  output logic              err
);
  vs_state_t        st_q;
  vs_layout_t       lay_dec, lay_q;
  logic             lay_ok;
  logic [1:0]       sz_q;
  logic             ld_q, err_q;
  logic [IDX_W-1:0] idx_q;
  logic [2:0]       kreg_q, elem_q;
  logic [63:0]      wdata, word;

  // named internal events
  logic cmd_take, cmd_bad, req_fire, rsp_take, elem_last, reg_last, reg_begin;
  assign cmd_take  = (st_q == S_IDLE) && cmd_valid;
  assign cmd_bad   = cmd_take && !lay_ok;
  assign req_fire  = (st_q == S_REQ) && mem_req_ready;
  assign rsp_take  = (st_q == S_WAIT) && mem_rsp_valid;
  assign elem_last = ({1'b0, elem_q} == vs_elems(sz_q) - 4'd1);
  assign reg_last  = (kreg_q == lay_q.nregs - 3'd1);
  assign reg_begin = (st_q == S_START);

  vseq_decode u_dec (.code(cmd_layout), .lay(lay_dec), .ok(lay_ok));

  vseq_agen #(.ADDR_W(ADDR_W)) u_agen (
    .clk(clk), .rst_n(rst_n), .load_cmd(cmd_take && lay_ok), .base(cmd_base),
    .reg_begin(reg_begin), .step(req_fire), .nregs(lay_q.nregs), .ilv(lay_q.ilv),
    .sz(sz_q), .kreg(kreg_q), .addr(mem_req_addr)
  );

  vseq_dpath u_dp (
    .clk(clk), .rst_n(rst_n), .capture(reg_begin && !ld_q), .clear(reg_begin && ld_q),
    .rsp_take(rsp_take), .sz(sz_q), .elem(elem_q), .rf_data(rf_rd_data),
    .rsp_data(mem_rsp_rdata), .wdata(wdata), .word(word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      lay_q  <= '0;
      sz_q   <= '0;
      ld_q   <= 1'b0;
      err_q  <= 1'b0;
      idx_q  <= '0;
      kreg_q <= '0;
      elem_q <= '0;
    end else begin
      err_q <= cmd_bad;
      case (st_q)
        S_IDLE: if (cmd_take && lay_ok) begin
          lay_q  <= lay_dec;
          sz_q   <= cmd_esize;
          ld_q   <= cmd_load;
          idx_q  <= cmd_reg;
          kreg_q <= '0;
          st_q   <= S_START;
        end
        S_START: begin
          elem_q <= '0;
          st_q   <= S_REQ;
        end
        S_REQ: if (req_fire) begin
          if (ld_q)           st_q <= S_WAIT;
          else if (elem_last) st_q <= S_NEXT;
          else                elem_q <= elem_q + 3'd1;
        end
        S_WAIT: if (rsp_take) begin
          if (elem_last) st_q <= S_NEXT;
          else begin
            elem_q <= elem_q + 3'd1;
            st_q   <= S_REQ;
          end
        end
        S_NEXT: begin
          idx_q  <= idx_q + IDX_W'(lay_q.spc);
          kreg_q <= kreg_q + 3'd1;
          st_q   <= reg_last ? S_FIN : S_START;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready     = (st_q == S_IDLE);
  assign mem_req_valid = (st_q == S_REQ);
  assign mem_req_size  = sz_q;
  assign mem_req_write = !ld_q;
  assign mem_req_wdata = ld_q ? 64'd0 : wdata;
  assign rf_rd_en      = reg_begin && !ld_q;
  assign rf_rd_idx     = idx_q;
  assign rf_wr_en      = (st_q == S_NEXT) && ld_q;
  assign rf_wr_idx     = idx_q;
  assign rf_wr_data    = word;
  assign done          = (st_q == S_FIN);
  assign err           = err_q;
endmodule

// File: rtl/vseq_chk.sv
module vseq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [3:0]        cmd_layout,
  input logic [1:0]        cmd_esize,
  input logic              cmd_load,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [1:0]        mem_req_size,
  input logic              mem_req_write,
  input logic [63:0]       mem_req_wdata,
  input logic              rf_rd_en,
  input logic              rf_wr_en,
  input logic              done,
  input logic              err,
  input logic              req_fire,
  input logic              rsp_take
);
  logic       pend_q, lat_ld;
  logic [1:0] lat_sz;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      lat_ld <= 1'b0;
      lat_sz <= '0;
    end else begin
      if (cmd_valid && cmd_ready) begin
        lat_ld <= cmd_load;
        lat_sz <= cmd_esize;
      end
      if (req_fire && !mem_req_write) pend_q <= 1'b1;
      else if (rsp_take)              pend_q <= 1'b0;
    end
  end

  a_r2_size_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_size == lat_sz);
  a_r5_write_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |-> lat_ld);
  a_r6_read_on_store: assert property (@(posedge clk) disable iff (!rst_n)
    rf_rd_en |-> !lat_ld);
  a_r6_wdata_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write && mem_req_size != 2'd3)
      |-> (mem_req_wdata >> (7'd8 << mem_req_size)) == 64'd0);
  a_r7_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready)
      |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata));
  a_r7_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !mem_req_valid);
  a_r7_rsp_expected: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take |-> pend_q);
  a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(cmd_valid && cmd_ready && cmd_layout > 4'd10));
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_req_valid && !rf_wr_en && !rf_rd_en);
endmodule

bind vstruct_seq vseq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_layout(cmd_layout), .cmd_esize(cmd_esize), .cmd_load(cmd_load),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_req_size(mem_req_size),
  .mem_req_write(mem_req_write), .mem_req_wdata(mem_req_wdata),
  .rf_rd_en(rf_rd_en), .rf_wr_en(rf_wr_en), .done(done), .err(err),
  .req_fire(req_fire), .rsp_take(rsp_take)
);

// File: tb/vstruct_seq_bench.sv
`timescale 1ns/1ps
module vstruct_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_ready, cmd_load;
  logic [3:0]  cmd_layout;
  logic [1:0]  cmd_esize;
  logic [4:0]  cmd_reg;
  logic [31:0] cmd_base;
  logic        mem_req_valid, mem_req_ready, mem_req_write, mem_rsp_valid;
  logic [31:0] mem_req_addr;
  logic [1:0]  mem_req_size;
  logic [63:0] mem_req_wdata, mem_rsp_rdata;
  logic        rf_rd_en, rf_wr_en, done, err;
  logic [4:0]  rf_rd_idx, rf_wr_idx;
  logic [63:0] rf_rd_data, rf_wr_data;

  logic [63:0] rf_model [32];
  logic [7:0]  mem [256];
  assign rf_rd_data = rf_model[rf_rd_idx];

  int checks = 0, errors = 0;
  bit stall = 0;
  int n_acc, n_wr, n_rd, n_done, n_err;
  logic [31:0] acc_addr [64];
  logic        acc_wr   [64];
  logic [1:0]  acc_sz   [64];
  logic [4:0]  wr_idx [8];
  logic [63:0] wr_dat [8];
  logic [4:0]  rd_idx [8];

  vstruct_seq u_vstruct_seq (.*);

  initial forever #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // memory responder: ready pattern, single-cycle-later read data
  initial begin
    bit pend = 0;
    logic [63:0] pdat = '0;
    int cyc = 0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_rdata = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        mem_rsp_valid = 1'b1; mem_rsp_rdata = pdat; pend = 0;
      end
      mem_req_ready = stall ? (cyc % 3 != 1) : 1'b1;
      cyc++;
      if (mem_req_valid && mem_req_ready) begin
        if (n_acc < 64) begin
          acc_addr[n_acc] = mem_req_addr; acc_wr[n_acc] = mem_req_write;
          acc_sz[n_acc] = mem_req_size;
        end
        n_acc++;
        if (mem_req_write) begin
          for (int b = 0; b < (1 << mem_req_size); b++)
            mem[(mem_req_addr + 32'(b)) & 32'hFF] = mem_req_wdata[8*b +: 8];
        end else begin
          for (int b = 0; b < 8; b++)
            pdat[8*b +: 8] = mem[(mem_req_addr + 32'(b)) & 32'hFF];
          pend = 1;
        end
      end
    end
  end

  // register-file and completion monitor
  initial forever begin
    @(negedge clk);
    if (rf_wr_en) begin
      if (n_wr < 8) begin wr_idx[n_wr] = rf_wr_idx; wr_dat[n_wr] = rf_wr_data; end
      rf_model[rf_wr_idx] = rf_wr_data;
      n_wr++;
    end
    if (rf_rd_en) begin
      if (n_rd < 8) rd_idx[n_rd] = rf_rd_idx;
      n_rd++;
    end
    if (done) n_done++;
    if (err) n_err++;
  end

  task automatic tb_lay(input int c, output int n, output int il, output int sp);
    case (c)
      0: begin n = 4; il = 4; sp = 1; end
      1: begin n = 4; il = 4; sp = 2; end
      2: begin n = 4; il = 1; sp = 1; end
      3: begin n = 4; il = 2; sp = 1; end
      4: begin n = 3; il = 3; sp = 1; end
      5: begin n = 3; il = 3; sp = 2; end
      6: begin n = 3; il = 1; sp = 1; end
      8: begin n = 2; il = 2; sp = 1; end
      9: begin n = 2; il = 2; sp = 2; end
      10: begin n = 2; il = 1; sp = 1; end
      default: begin n = 1; il = 1; sp = 1; end
    endcase
  endtask

  task automatic clear_logs();
    n_acc = 0; n_wr = 0; n_rd = 0; n_done = 0; n_err = 0;
  endtask

  task automatic prime();
    for (int j = 0; j < 256; j++) mem[j] = 8'(j * 37 + 11);
    for (int j = 0; j < 32; j++)
      rf_model[j] = 64'h0F1E_2D3C_4B5A_6978 ^ (64'(j) * 64'h0101_0304_0507_0911);
  endtask

  task automatic run_cmd(input int lay, input int sz, input bit ld, input int rg,
                         input int bs, input bit stl);
    int n, il, sp, esz, epr, cur, st, a, ne, bad;
    logic [31:0] ea [64];
    logic [4:0]  eidx [4];
    logic [63:0] edat [4];
    logic [7:0]  emem [256];
    prime();
    tb_lay(lay, n, il, sp);
    esz = 1 << sz; epr = 8 / esz; ne = 0; cur = bs;
    for (int j = 0; j < 256; j++) emem[j] = mem[j];
    for (int k = 0; k < n; k++) begin
      eidx[k] = 5'((rg + k * sp) % 32);
      edat[k] = '0;
      if (il > 2 || (il == 2 && n == 2)) st = bs + k * esz;
      else if (il == 2 && n == 4 && k == 2) st = bs + esz;
      else st = cur;
      for (int i = 0; i < epr; i++) begin
        a = st + i * esz * il;
        ea[ne] = 32'(a); ne++;
        for (int b = 0; b < esz; b++) begin
          if (ld) edat[k][8*(i*esz+b) +: 8] = mem[(a + b) & 255];
          else    emem[(a + b) & 255] = rf_model[eidx[k]][8*(i*esz+b) +: 8];
        end
        cur = a + esz * il;
      end
    end
    stall = stl;
    clear_logs();
    @(negedge clk);
    cmd_valid = 1'b1; cmd_layout = 4'(lay); cmd_esize = 2'(sz); cmd_load = ld;
    cmd_reg = 5'(rg); cmd_base = 32'(bs);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!mem_req_valid && !cmd_ready, "R9", "set-up cycle quiet", 64'(mem_req_valid), 0);
    @(negedge clk);
    chk(mem_req_valid, "R9", "first request in second cycle", 64'(mem_req_valid), 1);
    for (int w = 0; w < 3000 && n_done == 0; w++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(n_done == 1, "R9", "done pulse count", 64'(n_done), 1);
    chk(n_acc == ne, "R1", "access count", 64'(n_acc), 64'(ne));
    for (int j = 0; j < ne && j < n_acc; j++) begin
      chk(acc_addr[j] == ea[j], "R4", $sformatf("address of access %0d (R3 stride)", j),
          64'(acc_addr[j]), 64'(ea[j]));
      chk(acc_sz[j] == 2'(sz) && acc_wr[j] == !ld, "R2",
          $sformatf("size/dir of access %0d", j), 64'({acc_wr[j], acc_sz[j]}),
          64'({!ld, 2'(sz)}));
    end
    if (ld) begin
      chk(n_wr == n && n_rd == 0, "R5", "register write/read counts",
          64'({n_wr[15:0], n_rd[15:0]}), 64'({n[15:0], 16'd0}));
      for (int k = 0; k < n && k < n_wr; k++) begin
        chk(wr_idx[k] == eidx[k], "R5", "write index", 64'(wr_idx[k]), 64'(eidx[k]));
        chk(wr_dat[k] == edat[k], "R5", "assembled value", wr_dat[k], edat[k]);
      end
    end else begin
      chk(n_rd == n && n_wr == 0, "R6", "register read/write counts",
          64'({n_rd[15:0], n_wr[15:0]}), 64'({n[15:0], 16'd0}));
      for (int k = 0; k < n && k < n_rd; k++)
        chk(rd_idx[k] == eidx[k], "R6", "read index", 64'(rd_idx[k]), 64'(eidx[k]));
      bad = 0;
      for (int j = 0; j < 256; j++) if (mem[j] !== emem[j]) bad++;
      chk(bad == 0, "R6", "stored bytes mismatching", 64'(bad), 0);
    end
  endtask

  task automatic t_reset();
    chk(cmd_ready && !mem_req_valid && !rf_wr_en && !rf_rd_en && !done && !err,
        "R9", "reset state", 64'({cmd_ready, mem_req_valid, rf_wr_en, rf_rd_en, done, err}),
        64'h20);
  endtask

  task automatic t_bad(input int lay);
    clear_logs();
    @(negedge clk);
    cmd_valid = 1'b1; cmd_layout = 4'(lay); cmd_esize = 2'd1; cmd_load = 1'b1;
    cmd_reg = 5'd3; cmd_base = 32'h40;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(err && cmd_ready && !mem_req_valid, "R8", "err pulse next cycle",
        64'({err, cmd_ready, mem_req_valid}), 64'b110);
    @(negedge clk);
    chk(!err, "R8", "err lasts one cycle", 64'(err), 0);
    repeat (6) @(negedge clk);
    chk(n_acc == 0 && n_wr == 0 && n_rd == 0 && n_done == 0 && n_err == 1, "R8",
        "no activity after rejected code",
        64'({n_acc[7:0], n_wr[7:0], n_rd[7:0], n_done[7:0], n_err[7:0]}), 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_layout = '0; cmd_esize = '0; cmd_load = 1'b0;
    cmd_reg = '0; cmd_base = '0;
    clear_logs();
    prime();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_cmd(0, 0, 1, 2, 32'h40, 0);    // R1 R3 R4 byte load, four lanes
    run_cmd(3, 1, 1, 4, 32'h80, 0);    // R4 pair restart of register 2
    run_cmd(6, 2, 1, 1, 32'h10, 0);    // R4 continuing address
    run_cmd(7, 3, 1, 9, 32'hC8, 0);    // R2 one access per register
    run_cmd(9, 0, 1, 30, 32'h20, 0);   // R5 spacing 2 wraps index
    run_cmd(1, 1, 0, 5, 32'h60, 0);    // R6 halfword store
    run_cmd(10, 2, 0, 12, 32'hF8, 1);  // R6 R7 store under stalls
    run_cmd(4, 0, 1, 20, 32'h33, 1);   // R7 load under stalls
    for (int c = 0; c < 11; c++) run_cmd(c, 1, c[0], c * 3, 32'h100 + 32'(c) * 8, 0); // R1
    t_bad(11);
    t_bad(15);
    run_cmd(5, 0, 0, 31, 32'h04, 0);   // R1 after rejection
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule